// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block sits between a CPU register bus and a byte-wide nonvolatile data memory. Software reaches it through three byte registers: a control register, an address register and a data register. A read is a single strobe: the addressed byte lands in the data register at once, and the CPU is asked to stall for a few cycles. A write takes two steps. Software first arms a short-lived master enable. While that enable is still live, software sets the write strobe. The block then captures the address and the data and programs the array.

Each write is timed by counting rising edges of a slow, free-running oscillator tick. The tick is brought into the CPU clock domain through a synchronizer. While a write is in flight, the write-strobe bit reads as one, read requests are dropped and the address register is frozen. When the programming time has passed, the block clears the busy bit. A level-sensitive ready interrupt is raised whenever the block is idle, its enable bit is set and the global interrupt enable input is high. A write cannot start while the external flash self-programming engine reports busy.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the control, address and data registers all read 0x00, and both `ready_irq_o` and `cpu_stall_o` are low.
- R2: Writing a control byte with bit 2 set arms the master enable, and control bit 2 reads back as 1. Hardware clears it on its own once ARM_CYCLES (4) clock edges have passed since the arming write.
- R3: A control write with bit 1 set starts a write only if it lands on one of the ARM_CYCLES edges after the arming write. Without arming, or once the window has closed, it has no effect: control bit 1 stays 0 and the memory keeps its old contents.
- R4: Control bit 1 reads 1 from the start of a write until the block has seen WRITE_TICKS rising edges of `slow_tick_i`. Hardware then clears it.
- R5: At completion, the byte held in the data register at the start of the write is stored at the address held at the start. Writes to the data register during programming do not change what is stored.
- R6: `ready_irq_o` is high exactly when no write is in flight, control bit 3 is set and `gie_i` is high.
- R7: While a write is in flight, writes to the address register are discarded, and read requests leave the data register unchanged and raise no stall.
- R8: A control write with bit 0 set, made while idle, loads the data register with the byte at the current address on that edge and holds `cpu_stall_o` high for READ_STALL (4) cycles.
- R9: An accepted write start holds `cpu_stall_o` high for WRITE_STALL (2) cycles.
- R10: A write strobe issued while `flash_busy_i` is high starts no write.
- R11: Control bit 0 and bits 7 to 4 always read as 0, whatever was written to them.
- R12: `reg_sel_i` chooses the register: 0 control, 1 address, 2 data. Code 3 reads 0x00 and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe for one cycle |
| reg_sel_i | input | 2 | Register select (0 control, 1 address, 2 data) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| flash_busy_i | input | 1 | Flash self-programming engine busy |
| slow_tick_i | input | 1 | Asynchronous slow oscillator used to time writes |
| ready_irq_o | output | 1 | Level ready interrupt |
| cpu_stall_o | output | 1 | Request for the CPU to stall |

## Verification
The bench probes the edges of the arming window by placing the strobe three and then four cycles after arming. A window that is off by one either loses a legal write or accepts a late one. In the middle of a write it rewrites the address and data registers and issues a read. A design that does not latch its operands, or does not lock them out, stores the wrong byte, moves the target address or overwrites the data register. It also measures the stall lengths and the busy time against the tick count, so a wrong stall length or a miscounted tick shows up as a length outside the expected range.

// File: rtl/nvm_pkg.sv
// Package: shared register-select codes and control-bit positions for the
// nonvolatile memory access controller. Assumes an 8-bit register bus.
package nvm_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } nvm_sel_e;

    localparam int BIT_IRQ_EN = 3;
    localparam int BIT_ARM    = 2;
    localparam int BIT_STROBE = 1;
    localparam int BIT_READ   = 0;

endpackage

// File: rtl/nvm_arm_window.sv
// Module: nvm_arm_window
// Opens a master-enable window of ARM_CYCLES clock edges when armed. The
// window is closed early when a write consumes it. Assumes arm_i and
// consume_i are single-cycle qualified requests from the register decode.
module nvm_arm_window #(
    parameter int ARM_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic consume_i,
    output logic armed_o
);
    localparam int CNT_W = $clog2(ARM_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load, consume or count down the remaining window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (consume_i) begin
            cnt_q <= '0;
        end else if (arm_i) begin
            cnt_q <= CNT_W'(ARM_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign armed_o = (cnt_q != '0);

    p_window_decay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !arm_i && !consume_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ARM_CYCLES));

endmodule

// File: rtl/nvm_prog_timer.sv
// Module: nvm_prog_timer
// Synchronizes the slow oscillator into the clock domain. It counts the
// tick's rising edges and holds busy_o for WRITE_TICKS of them after a start.
// done_o marks the cycle on which programming completes. Assumes start_i is
// never raised while busy_o is high.
module nvm_prog_timer #(
    parameter int WRITE_TICKS = 8448,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick_i,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(WRITE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_TICKS - 1);

    logic [SYNC_STAGES:0] sync_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 busy_q;
    logic                 tick_rise;

    // Purpose: synchronizer chain plus one edge-detect stage.
    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= slow_tick_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign tick_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
    assign done_o    = busy_q && tick_rise && (cnt_q == LAST);

    // Purpose: count tick edges during programming and end the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q && tick_rise) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign busy_o = busy_q;

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_o) |=> busy_q);

    p_done_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(cnt_q) == LAST));

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q);

endmodule

// File: rtl/nvm_stall_gen.sv
// Module: nvm_stall_gen
// Holds the CPU stall request for a fixed number of cycles after a read or
// a write start. Assumes the two go pulses never coincide.
module nvm_stall_gen #(
    parameter int READ_STALL  = 4,
    parameter int WRITE_STALL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_go_i,
    input  logic write_go_i,
    output logic stall_o
);
    localparam int MAXS  = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
    localparam int CNT_W = $clog2(MAXS + 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load the stall length and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (write_go_i) begin
            cnt_q <= CNT_W'(WRITE_STALL);
        end else if (read_go_i) begin
            cnt_q <= CNT_W'(READ_STALL);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign stall_o = (cnt_q != '0);

    p_stall_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAXS));

    p_stall_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        read_go_i |=> stall_o);

    p_stall_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        write_go_i |=> stall_o);

    p_go_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(read_go_i && write_go_i));

endmodule

// File: rtl/nvm_array.sv
// Module: nvm_array
// Behavioural byte array that stands in for the nonvolatile cells. It has
// one synchronous write port and a combinational read port. Its contents
// are not reset, since a real array keeps its data across resets.
module nvm_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Purpose: commit a programmed byte.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/nvm_ctrl.sv
// Module: nvm_ctrl (top)
// Register-mapped access controller for a byte-wide nonvolatile memory. It
// decodes control, address and data registers and enforces the arm-then-
// strobe write sequence. Writes are timed from a slow tick. The block drives
// the ready interrupt and the CPU stall request. Assumes ADDR_W <= 8 and one
// register access per cycle.
module nvm_ctrl #(
    parameter int ADDR_W      = 8,
    parameter int WRITE_TICKS = 8448,
    parameter int ARM_CYCLES  = 4,
    parameter int READ_STALL  = 4,
    parameter int WRITE_STALL = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en_i,
    input  logic [1:0] reg_sel_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       gie_i,
    input  logic       flash_busy_i,
    input  logic       slow_tick_i,
    output logic       ready_irq_o,
    output logic       cpu_stall_o
);
    import nvm_pkg::*;

    localparam int DATA_W = 8;

    nvm_sel_e           sel;
    logic               ctrl_wr, addr_wr, data_wr;
    logic               arm_req, strobe_req, read_req;
    logic               armed, busy, done;
    logic               start_wr, read_go;
    logic               irq_en_q;
    logic [ADDR_W-1:0]  addr_q, pend_addr_q;
    logic [DATA_W-1:0]  data_q, pend_data_q, mem_rdata;

    assign sel        = nvm_sel_e'(reg_sel_i);
    assign ctrl_wr    = reg_wr_en_i && (sel == SEL_CTRL);
    assign addr_wr    = reg_wr_en_i && (sel == SEL_ADDR);
    assign data_wr    = reg_wr_en_i && (sel == SEL_DATA);
    assign arm_req    = ctrl_wr && reg_wdata_i[BIT_ARM];
    assign strobe_req = ctrl_wr && reg_wdata_i[BIT_STROBE];
    assign read_req   = ctrl_wr && reg_wdata_i[BIT_READ];
    assign start_wr   = strobe_req && armed && !busy && !flash_busy_i;
    assign read_go    = read_req && !busy && !start_wr;

    nvm_arm_window #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_req),
        .consume_i(start_wr),
        .armed_o  (armed)
    );

    nvm_prog_timer #(.WRITE_TICKS(WRITE_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick_i(slow_tick_i),
        .start_i    (start_wr),
        .busy_o     (busy),
        .done_o     (done)
    );

    nvm_stall_gen #(.READ_STALL(READ_STALL), .WRITE_STALL(WRITE_STALL)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_go_i (read_go),
        .write_go_i(start_wr),
        .stall_o   (cpu_stall_o)
    );

    nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .we_i   (done),
        .waddr_i(pend_addr_q),
        .wdata_i(pend_data_q),
        .raddr_i(addr_q),
        .rdata_o(mem_rdata)
    );

    // Purpose: interrupt enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_en_q <= 1'b0;
        else if (ctrl_wr) irq_en_q <= reg_wdata_i[BIT_IRQ_EN];
    end

    // Purpose: address register, frozen while a write is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                addr_q <= '0;
        else if (addr_wr && !busy) addr_q <= reg_wdata_i[ADDR_W-1:0];
    end

    // Purpose: data register, loaded by software or by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (read_go) data_q <= mem_rdata;
        else if (data_wr) data_q <= reg_wdata_i;
    end

    // Purpose: capture the write operands when programming starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr_q <= '0;
            pend_data_q <= '0;
        end else if (start_wr) begin
            pend_addr_q <= addr_q;
            pend_data_q <= data_q;
        end
    end

    // Purpose: read-back multiplexer for the selected register.
    always_comb begin
        reg_rdata_o = '0;
        case (sel)
            SEL_CTRL: begin
                reg_rdata_o[BIT_IRQ_EN] = irq_en_q;
                reg_rdata_o[BIT_ARM]    = armed;
                reg_rdata_o[BIT_STROBE] = busy;
            end
            SEL_ADDR: reg_rdata_o[ADDR_W-1:0] = addr_q;
            SEL_DATA: reg_rdata_o = data_q;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign ready_irq_o = !busy && irq_en_q && gie_i;

    p_start_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));

    p_start_no_flash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(flash_busy_i));

    p_addr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready_irq_o);

    p_operands_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pend_addr_q) && $stable(pend_data_q)));

endmodule

// File: tb/nvm_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvm_ctrl_tb_top;
    localparam int CLK_P     = 10;
    localparam int TICK_HALF = 21;
    localparam int TICKS     = 5;
    localparam int DUR_LO    = ((TICKS - 1) * 2 * TICK_HALF) / CLK_P;
    localparam int DUR_HI    = ((TICKS + 1) * 2 * TICK_HALF) / CLK_P + 4;
    localparam logic [1:0] S_CTRL = 2'd0;
    localparam logic [1:0] S_ADDR = 2'd1;
    localparam logic [1:0] S_DATA = 2'd2;
    localparam logic [1:0] S_NONE = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       flash_busy = 1'b0;
    logic       slow_tick = 1'b0;
    logic       ready_irq;
    logic       cpu_stall;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mem [256];
    logic       valid   [256];

    nvm_ctrl #(.WRITE_TICKS(TICKS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en_i (reg_wr_en),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .gie_i       (gie),
        .flash_busy_i(flash_busy),
        .slow_tick_i (slow_tick),
        .ready_irq_o (ready_irq),
        .cpu_stall_o (cpu_stall)
    );

    always #(CLK_P / 2) clk = ~clk;
    always #(TICK_HALF) slow_tick = ~slow_tick;

    function automatic logic [7:0] exp_ctrl(input logic ie, input logic arm, input logic bsy);
        return {4'b0000, ie, arm, bsy, 1'b0};
    endfunction

    function automatic logic exp_irq(input logic ie, input logic g, input logic bsy);
        return ie && g && !bsy;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        reg_sel   = s;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (cpu_stall && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] v;
        n = 0;
        rd(S_CTRL, v);
        while (v[1] && n < 2000) begin
            @(negedge clk);
            n++;
            rd(S_CTRL, v);
        end
    endtask

    // Full write sequence; returns with the start edge just passed.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int gap,
                            input logic fb, input logic ie, input logic exp_ok);
        logic [7:0] v;
        int n;
        wr(S_ADDR, a);
        wr(S_DATA, d);
        wr(S_CTRL, {4'b0, ie, 3'b100});
        repeat (gap) @(negedge clk);
        flash_busy = fb;
        wr(S_CTRL, {4'b0, ie, 3'b010});
        flash_busy = 1'b0;
        rd(S_CTRL, v);
        chk(exp_ok ? "R3 strobe in window accepted" : "R3/R10 strobe rejected", v[1], exp_ok);
        if (exp_ok) begin
            count_stall(n);
            chk("R9 write stall length", n, 2);
        end
    endtask

    task automatic do_read(input logic [7:0] a, input logic ie, output logic [7:0] v);
        int n;
        wr(S_ADDR, a);
        wr(S_CTRL, {4'b0, ie, 3'b001});
        count_stall(n);
        chk("R8 read stall length", n, 4);
        rd(S_DATA, v);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, m;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) valid[i] = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(S_CTRL, v); chk("R1 ctrl reset", v, 8'h00);
        rd(S_ADDR, v); chk("R1 addr reset", v, 8'h00);
        rd(S_DATA, v); chk("R1 data reset", v, 8'h00);
        chk("R1 irq low", ready_irq, 1'b0);
        chk("R1 stall low", cpu_stall, 1'b0);

        // R12 register map
        wr(S_ADDR, 8'h3C); rd(S_ADDR, v); chk("R12 addr readback", v, 8'h3C);
        wr(S_DATA, 8'hA5); rd(S_DATA, v); chk("R12 data readback", v, 8'hA5);
        wr(S_NONE, 8'hFF); rd(S_NONE, v); chk("R12 select 3 reads zero", v, 8'h00);
        rd(S_CTRL, v); chk("R12 select 3 write ignored", v, 8'h00);

        // R11 unused bits
        wr(S_CTRL, 8'hF0); rd(S_CTRL, v); chk("R11 upper bits read zero", v, exp_ctrl(1'b0, 1'b0, 1'b0));

        // R2 window self-clears
        wr(S_CTRL, 8'h04); rd(S_CTRL, v); chk("R2 arm visible", v, exp_ctrl(1'b0, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        rd(S_CTRL, v); chk("R2 arm still set at last edge", v[2], 1'b1);
        @(negedge clk);
        rd(S_CTRL, v); chk("R2 arm cleared by hardware", v[2], 1'b0);

        // R3 strobe without arming
        wr(S_CTRL, 8'h02); rd(S_CTRL, v); chk("R3 unarmed strobe ignored", v[1], 1'b0);
        // R3 late strobe, then latest legal strobe
        do_write(8'h21, 8'hC3, 4, 1'b0, 1'b0, 1'b0);
        do_write(8'h21, 8'hC3, 3, 1'b0, 1'b0, 1'b1);
        wait_idle(m);
        chk("R4 busy duration in range", ((m + 2) >= DUR_LO) && ((m + 2) <= DUR_HI), 1'b1);
        exp_mem[8'h21] = 8'hC3; valid[8'h21] = 1'b1;
        do_read(8'h21, 1'b0, v); chk("R8 read back programmed byte", v, 8'hC3);
        rd(S_CTRL, v); chk("R11 read bit reads zero", v[0], 1'b0);

        // R5/R6/R7 activity during a write
        gie = 1'b1;
        do_write(8'h10, 8'h5A, 0, 1'b0, 1'b1, 1'b1);
        chk("R6 irq low while busy", ready_irq, 1'b0);
        wr(S_ADDR, 8'h20); rd(S_ADDR, v); chk("R7 address locked", v, 8'h10);
        wr(S_DATA, 8'h77);
        wr(S_CTRL, 8'h09);
        chk("R7 ignored read raises no stall", cpu_stall, 1'b0);
        rd(S_DATA, v); chk("R7 ignored read keeps data", v, 8'h77);
        wait_idle(m);
        chk("R4 busy cleared by hardware", m < 2000, 1'b1);
        chk("R6 irq high when idle", ready_irq, exp_irq(1'b1, gie, 1'b0));
        gie = 1'b0; #1;
        chk("R6 irq follows gie", ready_irq, exp_irq(1'b1, gie, 1'b0));
        exp_mem[8'h10] = 8'h5A; valid[8'h10] = 1'b1;
        do_read(8'h10, 1'b0, v); chk("R5 captured data stored", v, 8'h5A);
        do_read(8'h20, 1'b0, v); rd(S_ADDR, v); chk("R5 address unlocked after write", v, 8'h20);

        // R10 flash busy blocks start
        do_write(8'h10, 8'h99, 1, 1'b1, 1'b0, 1'b0);
        do_read(8'h10, 1'b0, v); chk("R10 memory unchanged", v, 8'h5A);

        // Random phase
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a, d;
            int gap;
            logic fb, ok, ie;
            a   = 8'($urandom);
            d   = 8'($urandom);
            gap = int'($urandom % 6);
            fb  = ($urandom % 8) == 0;
            ie  = 1'($urandom);
            gie = 1'($urandom);
            ok  = (gap <= 3) && !fb;
            do_write(a, d, gap, fb, ie, ok);
            if (ok) begin
                chk("R6 random irq while busy", ready_irq, exp_irq(ie, gie, 1'b1));
                wait_idle(m);
                chk("R4 random duration", ((m + 2) >= DUR_LO) && ((m + 2) <= DUR_HI), 1'b1);
                exp_mem[a] = d; valid[a] = 1'b1;
            end
            chk("R6 random irq idle", ready_irq, exp_irq(ie, gie, 1'b0));
            if (valid[a]) begin
                do_read(a, ie, v);
                chk("R5/R8 random readback", v, exp_mem[a]);
            end
            n = 0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule